// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block screens each bus access against eight programmable protection regions. Each region has the following fields:

- an enable bit;
- a base address;
- a size exponent;
- an owner process ID;
- a rule that says what processes other than the owner may do there.

For each access the checker takes the address, the requesting process ID and the access kind (read, write or execute). One cycle later it answers with allow or deny and a fault code. It raises a halt request when a non-owner tries to execute from a region marked as an execute trap. It also keeps the address of the most recent denied access.

Regions are loaded through a single-cycle write port that selects a region by index. The sizes of regions are powers of two. When regions overlap, the one with the higher index decides the outcome. An address that falls in no enabled region is allowed under a permissive background rule.

Top module: `region_guard`

## Requirements
- R1: There are eight regions, each loaded independently by a write-port cycle (`cfg_we`=1, `cfg_idx` selects the region). An access presented in the same cycle as a write is judged with the old settings, and an access in the following cycle is judged with the new ones.
- R2: A region of size exponent n covers 2^n bytes. Values of n below 5 are treated as 5. The low n bits of the stored base are ignored, and an address hits when its bits above n equal those of the base.
- R3: The process whose ID equals a region's owner field is always allowed read, write and execute in that region.
- R4: For non-owners, rule code 0 (open) allows every kind of access, and rule code 2 (blocked) denies every kind of access.
- R5: For non-owners, rule code 1 (read-only) allows reads and denies writes and executes.
- R6: For non-owners, rule code 3 (trap) denies every kind of access. An execute attempt under this rule also drives `rsp_halt` high; reads and writes never do.
- R7: When several enabled regions hit, only the hit region with the highest index decides allow, fault and halt.
- R8: An access that hits no enabled region is allowed. A region with its enable bit clear never takes part in a check.
- R9: Access kind codes are 0 read, 1 write, 2 execute, and 3 is treated as read. Fault codes are 0 none, 1 read denied, 2 write denied, 3 execute denied. A denied access reports the code for its kind, and an allowed access reports 0.
- R10: `fault_addr` takes the address of every denied access and holds its value through allowed accesses and idle cycles.
- R11: `rsp_valid` is high in exactly the cycle after an access is presented. When `rsp_valid` is low, `rsp_allow`, `rsp_halt` and `rsp_fault` are all 0.
- R12: While reset is asserted, every output is 0 and every region is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Region write strobe |
| cfg_idx | input | 3 | Index of the region to write |
| cfg_en | input | 1 | Enable bit to store |
| cfg_base | input | 32 | Base address to store |
| cfg_size | input | 5 | Size exponent to store (minimum 5) |
| cfg_owner | input | 4 | Owner process ID to store |
| cfg_rule | input | 2 | Rule for non-owners: 0 open, 1 read-only, 2 blocked, 3 trap |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_pid | input | 4 | Requesting process ID |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 read |
| rsp_valid | output | 1 | Verdict valid |
| rsp_allow | output | 1 | Access allowed |
| rsp_fault | output | 2 | Fault code |
| rsp_halt | output | 1 | Halt request for a trapped execute |
| fault_addr | output | 32 | Address of the last denied access |

## Verification
Region state that is stored wrongly shows up at the ports only when an access lands in the affected region. A bad base, size or owner then gives a wrong allow bit or fault code in the cycle right after that access. A wrong fault address stays visible on `fault_addr` until the next denial, so it is checked after every access. Errors in the overlap priority appear only for addresses covered by two enabled regions with different rules. For that reason, both the random and the directed stimulus crowd the regions into a small address window so that overlaps are common.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef enum logic [1:0] {
    RULE_OPEN   = 2'b00,
    RULE_RDONLY = 2'b01,
    RULE_BLOCK  = 2'b10,
    RULE_TRAP   = 2'b11
  } rule_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_READ  = 2'b01,
    FLT_WRITE = 2'b10,
    FLT_EXEC  = 2'b11
  } fault_e;

  localparam int MIN_LOG2 = 5;
endpackage

// File: rtl/rg_bank.sv
module rg_bank
  import rg_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int ADDR_W = 32,
  parameter int PID_W  = 4,
  parameter int SZ_W   = 5,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [SZ_W-1:0]   wr_size,
  input  logic [PID_W-1:0]  wr_owner,
  input  rule_e             wr_rule,
  output logic              en_q    [NREG],
  output logic [ADDR_W-1:0] base_q  [NREG],
  output logic [SZ_W-1:0]   size_q  [NREG],
  output logic [PID_W-1:0]  owner_q [NREG],
  output rule_e             rule_q  [NREG]
);
  localparam logic [SZ_W-1:0] SZ_MIN = SZ_W'(MIN_LOG2);

  logic [SZ_W-1:0] size_clamped;
  assign size_clamped = (wr_size < SZ_MIN) ? SZ_MIN : wr_size;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic              sel;
    logic              en_d;
    logic [ADDR_W-1:0] base_d;
    logic [SZ_W-1:0]   size_d;
    logic [PID_W-1:0]  owner_d;
    rule_e             rule_d;

    assign sel = we && (idx == IDX_W'(g));

    always_comb begin
      en_d    = en_q[g];
      base_d  = base_q[g];
      size_d  = size_q[g];
      owner_d = owner_q[g];
      rule_d  = rule_q[g];
      if (sel) begin
        en_d    = wr_en;
        base_d  = wr_base;
        size_d  = size_clamped;
        owner_d = wr_owner;
        rule_d  = wr_rule;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[g]    <= 1'b0;
        base_q[g]  <= '0;
        size_q[g]  <= SZ_MIN;
        owner_q[g] <= '0;
        rule_q[g]  <= RULE_OPEN;
      end else begin
        en_q[g]    <= en_d;
        base_q[g]  <= base_d;
        size_q[g]  <= size_d;
        owner_q[g] <= owner_d;
        rule_q[g]  <= rule_d;
      end
    end
  end
endmodule

// File: rtl/rg_match.sv
module rg_match
  import rg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PID_W  = 4,
  parameter int SZ_W   = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PID_W-1:0]  pid,
  input  kind_e             kind,
  input  logic              en,
  input  logic [ADDR_W-1:0] base,
  input  logic [SZ_W-1:0]   size,
  input  logic [PID_W-1:0]  owner,
  input  rule_e             rule,
  output logic              hit,
  output logic              deny,
  output logic              trap
);
  logic [ADDR_W-1:0] keep;
  logic              is_owner;

  // Keep the bits at and above the size exponent for the compare.
  always_comb begin
    for (int b = 0; b < ADDR_W; b++) begin
      keep[b] = (b >= int'(size));
    end
  end

  assign hit      = en && (((addr ^ base) & keep) == '0);
  assign is_owner = (pid == owner);

  always_comb begin
    deny = 1'b0;
    if (!is_owner) begin
      case (rule)
        RULE_OPEN:   deny = 1'b0;
        RULE_RDONLY: deny = (kind == ACC_WRITE) || (kind == ACC_EXEC);
        default:     deny = 1'b1;
      endcase
    end
  end

  assign trap = !is_owner && (rule == RULE_TRAP) && (kind == ACC_EXEC);
endmodule

// File: rtl/rg_pick.sv
module rg_pick #(
  parameter int NREG = 8
) (
  input  logic [NREG-1:0] hit,
  input  logic [NREG-1:0] deny,
  input  logic [NREG-1:0] trap,
  output logic            deny_o,
  output logic            trap_o
);
  // Ascending scan: a later (higher-index) hit overrides earlier ones.
  always_comb begin
    deny_o = 1'b0;
    trap_o = 1'b0;
    for (int r = 0; r < NREG; r++) begin
      if (hit[r]) begin
        deny_o = deny[r];
        trap_o = trap[r];
      end
    end
  end
endmodule

// File: rtl/region_guard.sv
module region_guard
  import rg_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int ADDR_W = 32,
  parameter int PID_W  = 4,
  parameter int SZ_W   = 5,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SZ_W-1:0]   cfg_size,
  input  logic [PID_W-1:0]  cfg_owner,
  input  logic [1:0]        cfg_rule,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [PID_W-1:0]  acc_pid,
  input  logic [1:0]        acc_kind,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic [1:0]        rsp_fault,
  output logic              rsp_halt,
  output logic [ADDR_W-1:0] fault_addr
);
  // Reset synchronizer: asserts asynchronously, releases on the clock.
  logic [1:0] rst_pipe;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic              en_q    [NREG];
  logic [ADDR_W-1:0] base_q  [NREG];
  logic [SZ_W-1:0]   size_q  [NREG];
  logic [PID_W-1:0]  owner_q [NREG];
  rule_e             rule_q  [NREG];

  rg_bank #(.NREG(NREG), .ADDR_W(ADDR_W), .PID_W(PID_W), .SZ_W(SZ_W)) u_bank (
    .clk(clk), .rst_n(rst_s_n), .we(cfg_we), .idx(cfg_idx), .wr_en(cfg_en),
    .wr_base(cfg_base), .wr_size(cfg_size), .wr_owner(cfg_owner),
    .wr_rule(rule_e'(cfg_rule)), .en_q(en_q), .base_q(base_q),
    .size_q(size_q), .owner_q(owner_q), .rule_q(rule_q)
  );

  kind_e           kind;
  logic [NREG-1:0] hit_v, deny_v, trap_v;
  assign kind = kind_e'(acc_kind);

  for (genvar g = 0; g < NREG; g++) begin : g_match
    rg_match #(.ADDR_W(ADDR_W), .PID_W(PID_W), .SZ_W(SZ_W)) u_match (
      .addr(acc_addr), .pid(acc_pid), .kind(kind), .en(en_q[g]),
      .base(base_q[g]), .size(size_q[g]), .owner(owner_q[g]),
      .rule(rule_q[g]), .hit(hit_v[g]), .deny(deny_v[g]), .trap(trap_v[g])
    );
  end

  logic deny_any, trap_any;
  rg_pick #(.NREG(NREG)) u_pick (
    .hit(hit_v), .deny(deny_v), .trap(trap_v),
    .deny_o(deny_any), .trap_o(trap_any)
  );

  // Next-state for the response registers.
  logic              valid_d, allow_d, halt_d;
  fault_e            fault_d;
  logic [ADDR_W-1:0] faddr_d;

  always_comb begin
    valid_d = acc_valid;
    allow_d = 1'b0;
    halt_d  = 1'b0;
    fault_d = FLT_NONE;
    faddr_d = fault_addr;
    if (acc_valid) begin
      allow_d = !deny_any;
      halt_d  = trap_any;
      if (deny_any) begin
        faddr_d = acc_addr;
        case (kind)
          ACC_WRITE: fault_d = FLT_WRITE;
          ACC_EXEC:  fault_d = FLT_EXEC;
          default:   fault_d = FLT_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rsp_valid  <= 1'b0;
      rsp_allow  <= 1'b0;
      rsp_halt   <= 1'b0;
      rsp_fault  <= FLT_NONE;
      fault_addr <= '0;
    end else begin
      rsp_valid  <= valid_d;
      rsp_allow  <= allow_d;
      rsp_halt   <= halt_d;
      rsp_fault  <= fault_d;
      fault_addr <= faddr_d;
    end
  end
endmodule

// File: rtl/rg_checker.sv
module rg_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              acc_valid,
  input logic              rsp_valid,
  input logic              rsp_allow,
  input logic [1:0]        rsp_fault,
  input logic              rsp_halt,
  input logic [ADDR_W-1:0] fault_addr
);
  // R11: response follows an access by one cycle
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_s_n)
    acc_valid |=> rsp_valid);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_s_n)
    !rsp_valid |-> (!rsp_allow && !rsp_halt && rsp_fault == 2'b00));
  // R9: a fault code accompanies exactly the denied verdicts
  a_r9_fault_iff_deny: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_valid |-> ((rsp_fault != 2'b00) == !rsp_allow));
  // R6: a halt request is only raised for a denied execute
  a_r6_halt_is_exec: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_halt |-> (rsp_valid && !rsp_allow && rsp_fault == 2'b11));
  // R10: the fault address only moves on a denial
  a_r10_faddr_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(rsp_valid && !rsp_allow) |-> $stable(fault_addr));
endmodule

bind region_guard rg_checker #(.ADDR_W(ADDR_W)) u_rg_checker (
  .clk(clk), .rst_s_n(rst_s_n), .acc_valid(acc_valid), .rsp_valid(rsp_valid),
  .rsp_allow(rsp_allow), .rsp_fault(rsp_fault), .rsp_halt(rsp_halt),
  .fault_addr(fault_addr)
);

// File: tb/tb_region_guard.sv
module tb_region_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_en;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_base;
  logic [4:0]  cfg_size;
  logic [3:0]  cfg_owner;
  logic [1:0]  cfg_rule;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic [3:0]  acc_pid;
  logic [1:0]  acc_kind;
  logic        rsp_valid, rsp_allow, rsp_halt;
  logic [1:0]  rsp_fault;
  logic [31:0] fault_addr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  region_guard dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_owner(cfg_owner), .cfg_rule(cfg_rule), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_pid(acc_pid), .acc_kind(acc_kind),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault),
    .rsp_halt(rsp_halt), .fault_addr(fault_addr)
  );

  // Reference model of the region table
  logic        m_en    [8];
  logic [31:0] m_base  [8];
  logic [4:0]  m_size  [8];
  logic [3:0]  m_owner [8];
  logic [1:0]  m_rule  [8];
  logic [31:0] m_faddr;

  // Returns {allow, halt, fault[1:0]}
  function automatic logic [3:0] ref_eval(input logic [31:0] a, input logic [3:0] p,
                                          input logic [1:0] k);
    logic deny = 1'b0;
    logic halt = 1'b0;
    logic [1:0] f = 2'd0;
    for (int r = 0; r < 8; r++) begin
      logic [31:0] hi;
      hi = 32'hFFFF_FFFF << m_size[r];
      if (m_en[r] && ((a & hi) == (m_base[r] & hi))) begin
        if (p == m_owner[r]) begin
          deny = 1'b0; halt = 1'b0;
        end else begin
          case (m_rule[r])
            2'd0: begin deny = 1'b0; halt = 1'b0; end
            2'd1: begin deny = (k == 2'd1 || k == 2'd2); halt = 1'b0; end
            2'd2: begin deny = 1'b1; halt = 1'b0; end
            default: begin deny = 1'b1; halt = (k == 2'd2); end
          endcase
        end
      end
    end
    if (deny) f = (k == 2'd1) ? 2'd2 : (k == 2'd2) ? 2'd3 : 2'd1;
    return {!deny, halt, f};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic void model_write(input logic [2:0] i, input logic e,
      input logic [31:0] b, input logic [4:0] s, input logic [3:0] o, input logic [1:0] r);
    m_en[i] = e; m_base[i] = b; m_size[i] = (s < 5'd5) ? 5'd5 : s;
    m_owner[i] = o; m_rule[i] = r;
  endfunction

  task automatic drive_cfg(input logic [2:0] i, input logic e, input logic [31:0] b,
                           input logic [4:0] s, input logic [3:0] o, input logic [1:0] r);
    cfg_we = 1'b1; cfg_idx = i; cfg_en = e; cfg_base = b;
    cfg_size = s; cfg_owner = o; cfg_rule = r;
  endtask

  task automatic do_cfg(input logic [2:0] i, input logic e, input logic [31:0] b,
                        input logic [4:0] s, input logic [3:0] o, input logic [1:0] r);
    drive_cfg(i, e, b, s, o, r);
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(i, e, b, s, o, r);
  endtask

  task automatic check_rsp(input string tag, input logic [3:0] e);
    chk(tag, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk(tag, "rsp_allow", {31'd0, rsp_allow}, {31'd0, e[3]});
    chk(tag, "rsp_halt", {31'd0, rsp_halt}, {31'd0, e[2]});
    chk(tag, "rsp_fault", {30'd0, rsp_fault}, {30'd0, e[1:0]});
    chk(tag, "fault_addr", fault_addr, m_faddr);
  endtask

  task automatic do_acc(input logic [31:0] a, input logic [3:0] p,
                        input logic [1:0] k, input string tag);
    logic [3:0] e;
    e = ref_eval(a, p, k);
    acc_valid = 1'b1; acc_addr = a; acc_pid = p; acc_kind = k;
    @(negedge clk);
    acc_valid = 1'b0;
    if (!e[3]) m_faddr = a;
    check_rsp(tag, e);
  endtask

  task automatic expect_acc(input logic [31:0] a, input logic [3:0] p, input logic [1:0] k,
                            input logic allow, input logic halt, input logic [1:0] f,
                            input string tag);
    do_acc(a, p, k, tag);
    chk(tag, "fixed allow", {31'd0, rsp_allow}, {31'd0, allow});
    chk(tag, "fixed halt", {31'd0, rsp_halt}, {31'd0, halt});
    chk(tag, "fixed fault", {30'd0, rsp_fault}, {30'd0, f});
  endtask

  initial begin : watchdog
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [3:0] e;
    void'($urandom(32'd1234));
    for (int r = 0; r < 8; r++) model_write(3'(r), 1'b0, 32'd0, 5'd5, 4'd0, 2'd0);
    m_faddr = 32'd0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_en = 1'b0; cfg_base = '0;
    cfg_size = '0; cfg_owner = '0; cfg_rule = '0;
    acc_valid = 1'b0; acc_addr = '0; acc_pid = '0; acc_kind = '0;
    repeat (3) @(negedge clk);
    // R12: outputs cleared during reset
    chk("R12", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R12", "rsp_allow", {31'd0, rsp_allow}, 32'd0);
    chk("R12", "rsp_fault", {30'd0, rsp_fault}, 32'd0);
    chk("R12", "fault_addr", fault_addr, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: empty table allows everything (R12: regions start disabled)
    expect_acc(32'h0000_1234, 4'd7, 2'd1, 1'b1, 1'b0, 2'd0, "R8");
    expect_acc(32'hFFFF_FFF0, 4'd2, 2'd2, 1'b1, 1'b0, 2'd0, "R12");

    // R4 blocked region 0: 0x1000, 256 bytes, owner 3
    do_cfg(3'd0, 1'b1, 32'h0000_1000, 5'd8, 4'd3, 2'd2);
    expect_acc(32'h0000_1010, 4'd3, 2'd1, 1'b1, 1'b0, 2'd0, "R3");
    expect_acc(32'h0000_1010, 4'd3, 2'd2, 1'b1, 1'b0, 2'd0, "R3");
    expect_acc(32'h0000_1020, 4'd5, 2'd0, 1'b0, 1'b0, 2'd1, "R4");
    chk("R10", "fault_addr", fault_addr, 32'h0000_1020);
    expect_acc(32'h0000_1024, 4'd5, 2'd1, 1'b0, 1'b0, 2'd2, "R9");
    expect_acc(32'h0000_1028, 4'd5, 2'd2, 1'b0, 1'b0, 2'd3, "R9");
    expect_acc(32'h0000_102C, 4'd5, 2'd3, 1'b0, 1'b0, 2'd1, "R9");
    expect_acc(32'h0000_10FF, 4'd5, 2'd0, 1'b0, 1'b0, 2'd1, "R2");
    expect_acc(32'h0000_1100, 4'd5, 2'd0, 1'b1, 1'b0, 2'd0, "R2");
    chk("R10", "fault_addr held", fault_addr, 32'h0000_10FF);
    // R2: unaligned base, low bits ignored
    do_cfg(3'd0, 1'b1, 32'h0000_1010, 5'd8, 4'd3, 2'd2);
    expect_acc(32'h0000_1004, 4'd6, 2'd1, 1'b0, 1'b0, 2'd2, "R2");

    // R5 read-only region 1: 0x2000, 32 bytes, owner 1
    do_cfg(3'd1, 1'b1, 32'h0000_2000, 5'd5, 4'd1, 2'd1);
    expect_acc(32'h0000_2004, 4'd2, 2'd0, 1'b1, 1'b0, 2'd0, "R5");
    expect_acc(32'h0000_2004, 4'd2, 2'd1, 1'b0, 1'b0, 2'd2, "R5");
    expect_acc(32'h0000_2008, 4'd2, 2'd2, 1'b0, 1'b0, 2'd3, "R5");
    expect_acc(32'h0000_2008, 4'd1, 2'd1, 1'b1, 1'b0, 2'd0, "R3");

    // R6 trap region 2: 0x3000, 64 bytes, owner 4
    do_cfg(3'd2, 1'b1, 32'h0000_3000, 5'd6, 4'd4, 2'd3);
    expect_acc(32'h0000_3010, 4'd9, 2'd2, 1'b0, 1'b1, 2'd3, "R6");
    expect_acc(32'h0000_3010, 4'd9, 2'd0, 1'b0, 1'b0, 2'd1, "R6");
    expect_acc(32'h0000_3014, 4'd9, 2'd1, 1'b0, 1'b0, 2'd2, "R6");
    expect_acc(32'h0000_3010, 4'd4, 2'd2, 1'b1, 1'b0, 2'd0, "R6");

    // R4 open region 3
    do_cfg(3'd3, 1'b1, 32'h0000_4000, 5'd7, 4'd1, 2'd0);
    expect_acc(32'h0000_4040, 4'd8, 2'd1, 1'b1, 1'b0, 2'd0, "R4");

    // R7 overlap: region 4 open over region 0, region 7 blocked inside it
    do_cfg(3'd4, 1'b1, 32'h0000_0000, 5'd14, 4'd0, 2'd0);
    expect_acc(32'h0000_1020, 4'd5, 2'd1, 1'b1, 1'b0, 2'd0, "R7");
    do_cfg(3'd7, 1'b1, 32'h0000_1000, 5'd5, 4'd0, 2'd2);
    expect_acc(32'h0000_1008, 4'd5, 2'd1, 1'b0, 1'b0, 2'd2, "R7");
    expect_acc(32'h0000_1040, 4'd5, 2'd1, 1'b1, 1'b0, 2'd0, "R7");

    // R2: size below minimum clamps to 32 bytes
    do_cfg(3'd5, 1'b1, 32'h0001_0000, 5'd2, 4'd0, 2'd2);
    expect_acc(32'h0001_001F, 4'd1, 2'd0, 1'b0, 1'b0, 2'd1, "R2");
    expect_acc(32'h0001_0020, 4'd1, 2'd0, 1'b1, 1'b0, 2'd0, "R2");

    // R1/R8: disabling in the same cycle as an access uses old settings
    drive_cfg(3'd5, 1'b0, 32'h0001_0000, 5'd5, 4'd0, 2'd2);
    e = ref_eval(32'h0001_0004, 4'd1, 2'd0);
    acc_valid = 1'b1; acc_addr = 32'h0001_0004; acc_pid = 4'd1; acc_kind = 2'd0;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    if (!e[3]) m_faddr = 32'h0001_0004;
    check_rsp("R1", e);
    chk("R1", "old settings deny", {31'd0, rsp_allow}, 32'd0);
    model_write(3'd5, 1'b0, 32'h0001_0000, 5'd5, 4'd0, 2'd2);
    expect_acc(32'h0001_0004, 4'd1, 2'd0, 1'b1, 1'b0, 2'd0, "R8");

    // R11: idle cycle output
    @(negedge clk);
    chk("R11", "idle valid", {31'd0, rsp_valid}, 32'd0);
    chk("R11", "idle allow", {31'd0, rsp_allow}, 32'd0);
    chk("R11", "idle fault", {30'd0, rsp_fault}, 32'd0);
    chk("R10", "idle faddr", fault_addr, m_faddr);

    // Random mix in a 16 KiB window to force overlaps
    for (int n = 0; n < 600; n++) begin
      if (($urandom % 5) == 0) begin
        do_cfg(3'($urandom % 8), 1'($urandom % 4 != 0), $urandom & 32'h3FFF,
               5'($urandom % 13), 4'($urandom % 4), 2'($urandom % 4));
      end
      do_acc($urandom & 32'h3FFF, 4'($urandom % 4), 2'($urandom % 4), "R7-rand");
      if (($urandom % 8) == 0) begin
        @(negedge clk);
        chk("R11", "rand idle", {31'd0, rsp_valid}, 32'd0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule